// File: doc/BRIEF.md
# Selectable-Strength Reed-Solomon Encoder

This block is a systematic Reed-Solomon encoder over GF(256). A 2-bit code picks how many parity symbols follow each message: 14, 16, 18 or 20. The nominal codes are (126,112), (194,178), (219,201) and (225,205). The message length is set by the caller, so shortened blocks use the same hardware.

While `calc` is high, each enabled cycle accepts one message symbol and copies it to the output. The parity accumulates in a 20-stage register chain. While `calc` is low, the chain shifts the parity out, highest-degree symbol first. It fills with zeros behind it, so after exactly 2t enabled cycles it is clear for the next block.

The code select is captured at the start of each block. Only the first 2t stages of the chain take part for the captured setting.

Top module: `rsenc_sel`

## Requirements
- R1: `rst_n` low clears every register at once, with no clock edge needed, so `sym_out` reads 0. Release is synchronised through two clock stages. `sym_out` stays 0 until a message enters.
- R2: On an enabled cycle with `calc` high, `sym_out` equals that cycle's `sym_in` right after the clock edge. That makes one enabled cycle of latency.
- R3: A block of k message symbols is followed by 2t enabled cycles with `calc` low. Read in output order (message first, then parity) as polynomial coefficients from the highest degree down, the 2t + k symbols evaluate to zero at alpha^120 through alpha^(119+2t). Here alpha = 0x02, the field polynomial is x^8+x^7+x^2+x+1 (reduction byte 0x87), and an all-zero message gives all-zero parity.
- R4: `code_sel` 00, 01, 10 and 11 select t = 7, 8, 9 and 10, that is 14, 16, 18 and 20 parity symbols.
- R5: `code_sel` is captured on the enabled cycle where `calc` is high and the previous enabled cycle had `calc` low. Changes to it later in the block have no effect on that block's parity.
- R6: With `clk_en` low, no register changes and `sym_out` holds, whatever `calc`, `sym_in` and `code_sel` do.
- R7: After the 2t parity cycles the chain is empty. A further enabled cycle with `calc` low outputs 0, and a new block may start on the very next enabled cycle.
- R8: Chain stages at or above position 2t hold zero. A block with fewer parity symbols is therefore correct right after a block with more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously |
| clk_en | input | 1 | Enables every data register |
| calc | input | 1 | High: accept message symbols; low: shift parity out |
| code_sel | input | 2 | Parity count select, captured at block start |
| sym_in | input | 8 | Message symbol |
| sym_out | output | 8 | Codeword symbol (message, then parity) |

## Verification
On every cycle, the assertions check three things: the output copies the message, the output freezes while the clock enable is low, and the captured select holds through a block. They also check that zeros enter the chain while parity drains and that unused stages stay zero. Whether the parity is correct can only be shown by the bench scenarios. For all four settings, the bench evaluates each emitted codeword at its generator roots. Its blocks run at full and shortened lengths, back to back, with enable bubbles, with the select changed mid-block and with a reset mid-block.

// File: rtl/rsenc_pkg.sv
`timescale 1ns/1ps
package rsenc_pkg;
  localparam int SYM_W      = 8;
  localparam int MIN_T      = 7;
  localparam int NUM_CODES  = 4;
  localparam int CODE_W     = $clog2(NUM_CODES);
  localparam int MAX_T      = MIN_T + NUM_CODES - 1;
  localparam int MAX_PAR    = 2 * MAX_T;
  localparam int FIRST_ROOT = 120;
  localparam logic [SYM_W-1:0] POLY_TAIL = 8'h87;
  localparam logic [SYM_W-1:0] ALPHA     = 8'h02;

  typedef logic [SYM_W-1:0]  sym_t;
  typedef logic [CODE_W-1:0] code_t;

  // GF(256) product, shift-and-add with reduction
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[SYM_W-2:0], 1'b0} ^ (sh[SYM_W-1] ? POLY_TAIL : '0);
    end
    return acc;
  endfunction

  function automatic sym_t gf_pow(int e);
    sym_t p;
    p = 8'h01;
    for (int i = 0; i < e; i++) p = gf_mul(p, ALPHA);
    return p;
  endfunction

  // Low coefficients g0..g(n-1) of the monic generator with n roots
  function automatic logic [MAX_PAR*SYM_W-1:0] gen_poly(int nroots);
    logic [(MAX_PAR+1)*SYM_W-1:0] c;
    sym_t root;
    c = '0;
    c[SYM_W-1:0] = 8'h01;
    root = gf_pow(FIRST_ROOT);
    for (int r = 0; r < nroots; r++) begin
      for (int i = MAX_PAR; i >= 1; i--)
        c[i*SYM_W +: SYM_W] = c[(i-1)*SYM_W +: SYM_W] ^ gf_mul(c[i*SYM_W +: SYM_W], root);
      c[SYM_W-1:0] = gf_mul(c[SYM_W-1:0], root);
      root = gf_mul(root, ALPHA);
    end
    return c[MAX_PAR*SYM_W-1:0];
  endfunction

  function automatic int par_len(code_t c);
    return 2 * (MIN_T + int'(c));
  endfunction
endpackage

// File: rtl/rsenc_rst_sync.sv
`timescale 1ns/1ps
module rsenc_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb sync_d = {sync_q[DEPTH-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[DEPTH-1];
endmodule

// File: rtl/rsenc_coef_mul.sv
`timescale 1ns/1ps
module rsenc_coef_mul
  import rsenc_pkg::*;
(
  input  sym_t                              fb,
  input  code_t                             code,
  output logic [MAX_PAR-1:0][SYM_W-1:0]     prod
);
  logic [NUM_CODES-1:0][MAX_PAR-1:0][SYM_W-1:0] cand;

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
    localparam int NPAR = 2 * (MIN_T + k);
    localparam logic [MAX_PAR*SYM_W-1:0] GCOEF = gen_poly(NPAR);
    for (genvar i = 0; i < MAX_PAR; i++) begin : g_stage
      if (i < NPAR) begin : g_on
        // constant operand: reduces to an XOR network
        assign cand[k][i] = gf_mul(fb, GCOEF[i*SYM_W +: SYM_W]);
      end else begin : g_off
        assign cand[k][i] = '0;
      end
    end
  end

  assign prod = cand[code];
endmodule

// File: rtl/rsenc_lfsr.sv
`timescale 1ns/1ps
module rsenc_lfsr
  import rsenc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  calc,
  input  code_t code,
  input  sym_t  din,
  output sym_t  top_sym
);
  logic [MAX_PAR-1:0][SYM_W-1:0] stage_q;
  logic [MAX_PAR-1:0][SYM_W-1:0] stage_d;
  logic [MAX_PAR-1:0][SYM_W-1:0] prod;
  sym_t fb;
  sym_t top;

  always_comb begin
    top = '0;
    for (int k = 0; k < NUM_CODES; k++)
      if (code == code_t'(k)) top = stage_q[2*(MIN_T+k)-1];
  end

  always_comb fb = calc ? (din ^ top) : '0;

  rsenc_coef_mul u_coef (
    .fb   (fb),
    .code (code),
    .prod (prod)
  );

  for (genvar i = 0; i < MAX_PAR; i++) begin : g_next
    if (i == 0) begin : g_first
      assign stage_d[i] = (i >= par_len(code)) ? '0 : prod[i];
    end else begin : g_rest
      assign stage_d[i] = (i >= par_len(code)) ? '0 : (stage_q[i-1] ^ prod[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  stage_q <= '0;
    else if (en) stage_q <= stage_d;
  end

  assign top_sym = top;

  for (genvar i = 0; i < MAX_PAR; i++) begin : g_chk
    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (i >= par_len(code))) |=> (stage_q[i] == '0)); // R8
  end

  AST_DRAIN_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !calc) |=> (stage_q[0] == '0)); // R7
endmodule

// File: rtl/rsenc_sel.sv
`timescale 1ns/1ps
module rsenc_sel
  import rsenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en,
  input  logic       calc,
  input  logic [1:0] code_sel,
  input  logic [7:0] sym_in,
  output logic [7:0] sym_out
);
  logic  rst_n_s;
  logic  calc_q, calc_d;
  code_t code_q, code_d, code_eff;
  sym_t  out_q, out_d;
  sym_t  top_sym;
  logic  start;

  rsenc_rst_sync #(.DEPTH(2)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  always_comb begin
    start    = clk_en && calc && !calc_q;
    code_eff = start ? code_t'(code_sel) : code_q;
    calc_d   = calc;
    code_d   = code_eff;
    out_d    = calc ? sym_t'(sym_in) : top_sym;
  end

  rsenc_lfsr u_chain (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en      (clk_en),
    .calc    (calc),
    .code    (code_eff),
    .din     (sym_t'(sym_in)),
    .top_sym (top_sym)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      calc_q <= 1'b0;
      code_q <= '0;
      out_q  <= '0;
    end else if (clk_en) begin
      calc_q <= calc_d;
      code_q <= code_d;
      out_q  <= out_d;
    end
  end

  assign sym_out = out_q;

  AST_MSG_PASS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (clk_en && calc) |=> (sym_out == $past(sym_in))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !clk_en |=> $stable(sym_out)); // R6
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(clk_en && calc && !calc_q) |=> $stable(code_q)); // R5
endmodule

// File: tb/rsenc_sel_tb.sv
`timescale 1ns/1ps
module rsenc_sel_tb;
  logic       clk = 1'b0;
  logic       rst_n, clk_en, calc;
  logic [1:0] code_sel;
  logic [7:0] sym_in, sym_out;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rsenc_sel u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .calc(calc),
    .code_sel(code_sel), .sym_in(sym_in), .sym_out(sym_out)
  );

  function automatic logic [7:0] fmul(logic [7:0] a, logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = x[7] ? ((x << 1) ^ 8'h87) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] fpow(int e);
    logic [7:0] p = 8'h01;
    for (int i = 0; i < e; i++) p = fmul(p, 8'h02);
    return p;
  endfunction

  function automatic int kfull(int code);
    case (code)
      0: return 112;
      1: return 178;
      2: return 201;
      default: return 205;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit ce, bit c, logic [7:0] d);
    @(negedge clk);
    clk_en = ce; calc = c; sym_in = d;
    @(posedge clk);
    #1;
  endtask

  task automatic bubble(bit on);
    logic [7:0] prev;
    if (on && ($urandom % 4 == 0)) begin
      prev = sym_out;
      step(1'b0, 1'($urandom), 8'($urandom));
      chk(sym_out == prev, "R6 hold while disabled", sym_out, prev);
    end
  endtask

  // mode 0 random, 1 zeros, 2 all ones
  task automatic run_block(int code, int k, int mode, bit bub, bit flip, bit trail, string tag);
    logic [7:0] cw [0:255];
    logic [7:0] d, s, a;
    int n = 0;
    int np = 2 * (7 + code);
    bit syn_ok = 1;
    code_sel = 2'(code);
    for (int j = 0; j < k; j++) begin
      bubble(bub);
      d = (mode == 1) ? 8'h00 : (mode == 2) ? 8'hFF : 8'($urandom);
      step(1'b1, 1'b1, d);
      chk(sym_out == d, "R2 message copied to output", sym_out, d);
      cw[n++] = sym_out;
      if (flip && j == 0) code_sel = 2'(code) ^ 2'(1 + $urandom % 3);
    end
    for (int j = 0; j < np; j++) begin
      bubble(bub);
      step(1'b1, 1'b0, 8'($urandom));
      if (mode == 1) chk(sym_out == 0, "R3 zero message gives zero parity", sym_out, 0);
      cw[n++] = sym_out;
    end
    for (int r = 0; r < np; r++) begin
      a = fpow(120 + r);
      s = 0;
      for (int i = 0; i < n; i++) s = fmul(s, a) ^ cw[i];
      if (s != 0) begin
        syn_ok = 0;
        $display("  root %0d syndrome %0h (code %0d k %0d)", 120 + r, s, code, k);
      end
    end
    chk(syn_ok, tag, syn_ok, 1);
    if (trail) begin
      step(1'b1, 1'b0, 8'($urandom));
      chk(sym_out == 0, "R7 chain empty after 2t shifts", sym_out, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd5171));
    rst_n = 0; clk_en = 0; calc = 0; code_sel = 0; sym_in = 0;
    repeat (3) @(posedge clk);
    #1 chk(sym_out == 0, "R1 output zero in reset", sym_out, 0);
    @(negedge clk) rst_n = 1;
    repeat (3) step(1'b1, 1'b0, 8'hA5);
    chk(sym_out == 0, "R1 output zero after release", sym_out, 0);

    // R4 every select at full length
    run_block(0, kfull(0), 0, 0, 0, 1, "R3 R4 code 00 t=7 full");
    run_block(1, kfull(1), 0, 0, 0, 1, "R3 R4 code 01 t=8 full");
    run_block(2, kfull(2), 0, 0, 0, 1, "R3 R4 code 10 t=9 full");
    run_block(3, kfull(3), 0, 0, 0, 1, "R3 R4 code 11 t=10 full");
    // directed corners
    run_block(3, 9, 1, 0, 0, 0, "R3 zero message");
    run_block(1, 12, 2, 0, 0, 0, "R3 all-ones message");
    for (int c = 0; c < 4; c++) run_block(c, 1, 0, 0, 0, 0, "R3 single symbol");
    // R8 wide block then narrow block back to back
    run_block(3, 20, 0, 0, 0, 0, "R8 t=10 before narrow");
    run_block(0, 30, 0, 0, 0, 1, "R8 t=7 after t=10");
    // R5 select flipped mid block
    run_block(2, 40, 0, 0, 1, 0, "R5 select change ignored");
    run_block(0, 25, 0, 1, 1, 1, "R5 R6 flip with bubbles");
    // random mix
    for (int b = 0; b < 24; b++) begin
      int c = $urandom % 4;
      run_block(c, 1 + $urandom % kfull(c), 0, 1, 1'($urandom), 1'($urandom), "R3 R7 random block");
    end

    // R1 reset in the middle of a block
    code_sel = 2'd2;
    for (int j = 0; j < 10; j++) step(1'b1, 1'b1, 8'($urandom));
    @(negedge clk) rst_n = 0;
    #1 chk(sym_out == 0, "R1 asynchronous clear", sym_out, 0);
    step(1'b1, 1'b1, 8'h5A);
    chk(sym_out == 0, "R1 held in reset", sym_out, 0);
    @(negedge clk) rst_n = 1;
    for (int j = 0; j < 3; j++) begin
      step(1'b1, 1'b0, 8'($urandom));
      chk(sym_out == 0, "R1 chain clear after reset", sym_out, 0);
    end
    run_block(1, 50, 0, 0, 0, 1, "R1 R3 block after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog all requirements actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule